// File: doc/BRIEF.md
# Self-Synchronizing Payload Scrambler

This block whitens link payload words before they reach the line encoder. Each output bit is the input bit XORed with the two scrambled bits sent 14 and 15 bit times earlier. Because the line bits alone decide the next output, a receiver locks onto the sequence without sharing a seed. The block takes one 32-bit word (four octets) per clock, qualified by a valid flag. The bit recurrence is fully unrolled across the word. The word is treated as a serial stream: bit 31 is sent first and bit 0 last, so the most significant octet leads.

A run-time enable selects between scrambled and plain payload. Both settings give the same one-cycle registered latency. While bypassed, the history register keeps tracking the raw line bits, so the recurrence stays continuous when scrambling is switched back on.

A second lane inside the same top module holds the matching descrambler. It computes each output bit from received bits only, so it can check a loopback path at the link's far end. Both lanes use a synchronous active-low reset that loads the 15-bit history to all ones.

Top module: `payload_scrambler`

## Requirements
- R1: While rst_n is low at a clock edge, both lanes clear their output valid and output data to zero and load their 15-bit history with all ones. The first word after reset is therefore scrambled against an all-ones history.
- R2: With the scramble enable high, a valid word is scrambled bit-serially from bit 31 down to bit 0. Each output bit is the input bit XOR the output bits 14 and 15 positions earlier, and this recurrence runs continuously across consecutive valid words.
- R3: Each lane's output valid equals its input valid one clock later. The output data of a valid word appears in that same cycle.
- R4: With the scramble enable low, a valid word leaves the scrambler lane unchanged, after the same one-cycle latency as a scrambled word.
- R5: During bypass the scrambler history shifts in the raw input bits. When scrambling resumes, the recurrence uses the last 15 line bits sent.
- R6: A cycle with input valid low changes neither the lane's output data nor its history.
- R7: With its enable high, the descrambler output bit equals the received bit XOR the received bits 14 and 15 positions earlier, in the same serial order as R2.
- R8: Feeding the scrambler output, with its valid and with the enable the word was sent with, into the descrambler reproduces the original payload two cycles after it entered the scrambler.
- R9: A descrambler whose history does not match the sender recovers by itself. Bits 16 down to 0 of the first received word are already correct, and every later word is fully correct.
- R10: With its enable low, the descrambler passes received words unchanged and its history still shifts in the received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both lanes |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_scr_en | input | 1 | Scrambler lane: 1 scrambles, 0 passes data through |
| tx_valid | input | 1 | Scrambler lane input word qualifier |
| tx_data | input | 32 | Plain payload word, bit 31 sent first |
| tx_out_valid | output | 1 | Scrambled word qualifier |
| tx_out_data | output | 32 | Scrambled (or bypassed) word |
| rx_dscr_en | input | 1 | Descrambler lane: 1 descrambles, 0 passes data through |
| rx_valid | input | 1 | Descrambler lane input word qualifier |
| rx_data | input | 32 | Received line word, bit 31 received first |
| rx_out_valid | output | 1 | Recovered word qualifier |
| rx_out_data | output | 32 | Recovered payload word |

## Verification
Every lane result is registered once, so the bench drives each word on a falling edge and compares that lane's outputs on the next falling edge, one cycle later. The loopback result is due two cycles after the plain word entered the scrambler. The bench therefore keeps the plain word and its enable for one extra cycle and feeds the observed scrambler output into the descrambler. On idle cycles no new value is due, and the bench expects the previous word to persist. In the recovery test a word is driven into the descrambler and its check falls on the following falling edge; the partial check on the first word and the full checks on later words follow that same rule.

// File: rtl/scr_pkg.sv
// Package scr_pkg
// Shared constants for the self-synchronizing scrambler lanes:
// history length and the two feedback tap distances of x^15 + x^14 + 1.
package scr_pkg;
    localparam int HIST_LEN = 15;
    localparam int TAP_NEAR = 14;
    localparam int TAP_FAR  = 15;
endpackage

// File: rtl/scr_core.sv
// Module scr_core
// Combinational, fully unrolled recurrence over one word.
// Bit W-1 is the earliest serial bit. FEEDBACK=1 builds the scrambler
// (taps come from produced bits); FEEDBACK=0 builds the descrambler
// (taps come from received bits). With en low the word passes through.
// Assumes W >= HIST_LEN so the next history lies wholly in this word.
module scr_core #(
    parameter int W        = 32,
    parameter bit FEEDBACK = 1'b1
) (
    input  logic [scr_pkg::HIST_LEN-1:0] hist,
    input  logic                         en,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 dout,
    output logic [scr_pkg::HIST_LEN-1:0] hist_next
);
    import scr_pkg::*;

    localparam int EXT_W = W + HIST_LEN;

    logic [EXT_W-1:0] ext;
    logic [W-1:0]     res;

    generate
        if (FEEDBACK) begin : g_self_feedback
            // Scrambler: each line bit feeds the taps of later bits.
            always_comb begin
                ext = {hist, {W{1'b0}}};
                res = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    res[i] = din[i] ^ (en & (ext[i + TAP_NEAR] ^ ext[i + TAP_FAR]));
                    ext[i] = en ? res[i] : din[i];
                end
            end
        end else begin : g_rx_feedback
            // Descrambler: taps come from the received bits only.
            always_comb begin
                ext = {hist, din};
                res = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    res[i] = din[i] ^ (en & (ext[i + TAP_NEAR] ^ ext[i + TAP_FAR]));
                end
            end
        end
    endgenerate

    assign dout      = res;
    assign hist_next = ext[HIST_LEN-1:0];
endmodule

// File: rtl/scr_lane.sv
// Module scr_lane
// One registered lane: history register, unrolled core, output register.
// Latency is one cycle in scrambling and in bypass. The history and the
// output only advance on valid cycles. Synchronous active-low reset.
module scr_lane #(
    parameter int W        = 32,
    parameter bit FEEDBACK = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    import scr_pkg::*;

    logic [HIST_LEN-1:0] hist;
    logic [HIST_LEN-1:0] hist_next;
    logic [W-1:0]        word_next;

    scr_core #(
        .W        (W),
        .FEEDBACK (FEEDBACK)
    ) i_core (
        .hist      (hist),
        .en        (en),
        .din       (in_data),
        .dout      (word_next),
        .hist_next (hist_next)
    );

    // Advance history and register the word on valid cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist      <= '1;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hist     <= hist_next;
                out_data <= word_next;
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && hist == '1));

    // R3
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !en) |=> out_data == $past(in_data));

    // R5
    raw_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !en) |=> hist == $past(in_data[HIST_LEN-1:0]));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(hist)));
endmodule

// File: rtl/payload_scrambler.sv
// Module payload_scrambler
// Top: a scrambler lane for outgoing payload and a matching descrambler
// lane for loopback checking. Words are OCTETS octets wide, most
// significant octet first on the line. Each lane has its own enable.
module payload_scrambler #(
    parameter int OCTETS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_scr_en,
    input  logic                  tx_valid,
    input  logic [OCTETS*8-1:0]   tx_data,
    output logic                  tx_out_valid,
    output logic [OCTETS*8-1:0]   tx_out_data,
    input  logic                  rx_dscr_en,
    input  logic                  rx_valid,
    input  logic [OCTETS*8-1:0]   rx_data,
    output logic                  rx_out_valid,
    output logic [OCTETS*8-1:0]   rx_out_data
);
    localparam int W = OCTETS * 8;

    // Outgoing lane with self feedback.
    scr_lane #(.W(W), .FEEDBACK(1'b1)) i_tx_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_scr_en),
        .in_valid  (tx_valid),
        .in_data   (tx_data),
        .out_valid (tx_out_valid),
        .out_data  (tx_out_data)
    );

    // Incoming lane fed forward from received bits.
    scr_lane #(.W(W), .FEEDBACK(1'b0)) i_rx_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_dscr_en),
        .in_valid  (rx_valid),
        .in_data   (rx_data),
        .out_valid (rx_out_valid),
        .out_data  (rx_out_data)
    );
endmodule

// File: tb/test_payload_scrambler.sv
`timescale 1ns/1ps
module test_payload_scrambler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_scr_en = 1'b1, tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        rx_dscr_en = 1'b1, rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        tx_out_valid, rx_out_valid;
    logic [31:0] tx_out_data, rx_out_data;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    payload_scrambler i_payload_scrambler (
        .clk(clk), .rst_n(rst_n),
        .tx_scr_en(tx_scr_en), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .rx_dscr_en(rx_dscr_en), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Serial model: sh[0] is the newest line bit, sh[k] is k+1 bits back.
    function automatic logic [46:0] model_scr(input logic [31:0] d, input logic en, input logic [14:0] sh);
        logic [31:0] o;
        logic b;
        o = '0;
        for (int j = 31; j >= 0; j--) begin
            b    = d[j] ^ (en & (sh[13] ^ sh[14]));
            o[j] = b;
            sh   = {sh[13:0], en ? b : d[j]};
        end
        return {sh, o};
    endfunction

    function automatic logic [46:0] model_dsc(input logic [31:0] d, input logic en, input logic [14:0] sh);
        logic [31:0] o;
        o = '0;
        for (int j = 31; j >= 0; j--) begin
            o[j] = d[j] ^ (en & (sh[13] ^ sh[14]));
            sh   = {sh[13:0], d[j]};
        end
        return {sh, o};
    endfunction

    function automatic logic [31:0] pattern(input int k, input logic [31:0] rnd);
        case (k % 5)
            0: return 32'h01010101 * k;
            1: return 32'h0;
            2: return 32'hffffffff;
            3: return 32'h1 << (k % 32);
            default: return rnd;
        endcase
    endfunction

    initial begin
        logic [14:0] tx_sh, rx_sh, ss_sh;
        logic [46:0] r;
        logic [31:0] exp_tx, exp_rx, plain_rx, last_plain, rnd;
        logic [31:0] ss_plain [4];
        logic        exp_txv, exp_rxv, last_en, seen_bypass, cur_bypass;
        tx_sh = '1; rx_sh = '1;
        exp_tx = '0; exp_rx = '0; plain_rx = '0; last_plain = '0;
        exp_txv = 1'b0; exp_rxv = 1'b0; last_en = 1'b1;
        seen_bypass = 1'b0; cur_bypass = 1'b0;
        rnd = 32'h9e3779b9;

        // R1: reset with busy inputs clears outputs
        tx_valid = 1'b1; tx_data = 32'hdeadbeef; rx_valid = 1'b1; rx_data = 32'h12345678;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(tx_out_valid == 1'b0 && rx_out_valid == 1'b0, "R1 valid", {30'b0, tx_out_valid, rx_out_valid}, 32'h0);
            chk(tx_out_data == 32'h0, "R1 tx data", tx_out_data, 32'h0);
            chk(rx_out_data == 32'h0, "R1 rx data", rx_out_data, 32'h0);
        end
        rst_n = 1'b1; tx_valid = 1'b0; rx_valid = 1'b0;

        // Main sweep with loopback; history assumed all ones (R1)
        for (int k = 0; k < 230; k++) begin
            logic        v, e;
            logic [31:0] d;
            @(negedge clk);
            if (k > 0) begin
                chk(tx_out_valid == exp_txv, "R3 tx valid", {31'b0, tx_out_valid}, {31'b0, exp_txv});
                if (!exp_txv)        chk(tx_out_data == exp_tx, "R6 tx hold", tx_out_data, exp_tx);
                else if (cur_bypass) chk(tx_out_data == exp_tx, "R4 tx bypass", tx_out_data, exp_tx);
                else if (seen_bypass) chk(tx_out_data == exp_tx, "R5 tx resume", tx_out_data, exp_tx);
                else                 chk(tx_out_data == exp_tx, "R2 tx scramble", tx_out_data, exp_tx);
                chk(rx_out_valid == exp_rxv, "R3 rx valid", {31'b0, rx_out_valid}, {31'b0, exp_rxv});
                chk(rx_out_data == exp_rx, "R7 R10 rx lane", rx_out_data, exp_rx);
                if (exp_rxv) chk(rx_out_data == plain_rx, "R8 loopback", rx_out_data, plain_rx);
            end
            // Loop the observed scrambler output into the descrambler
            rx_valid = tx_out_valid; rx_data = tx_out_data; rx_dscr_en = last_en;
            exp_rxv = tx_out_valid;
            if (tx_out_valid) begin
                r = model_dsc(tx_out_data, last_en, rx_sh);
                rx_sh = r[46:32]; exp_rx = r[31:0]; plain_rx = last_plain;
            end
            // New scrambler word
            rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
            v = (k % 7 != 3) && (k < 225);
            e = !(k >= 60 && k < 80);
            d = pattern(k, rnd);
            tx_valid = v; tx_scr_en = e; tx_data = d;
            exp_txv = v;
            if (v) begin
                r = model_scr(d, e, tx_sh);
                tx_sh = r[46:32]; exp_tx = r[31:0];
                last_plain = d; last_en = e;
                cur_bypass = !e;
                if (!e) seen_bypass = 1'b1;
            end
        end

        // R9: descrambler starts from a mismatched history
        @(negedge clk);
        tx_valid = 1'b0; rx_dscr_en = 1'b1;
        ss_sh = 15'h2b5c;
        for (int j = 0; j < 5; j++) begin
            if (j > 0) begin
                if (j == 1) chk(rx_out_data[16:0] == ss_plain[0][16:0], "R9 first word low bits",
                                {15'b0, rx_out_data[16:0]}, {15'b0, ss_plain[0][16:0]});
                else        chk(rx_out_data == ss_plain[j-1], "R9 later word", rx_out_data, ss_plain[j-1]);
            end
            if (j < 4) begin
                ss_plain[j] = 32'ha5c3_0f00 ^ (32'h1111_1111 * j);
                r = model_scr(ss_plain[j], 1'b1, ss_sh);
                ss_sh = r[46:32];
                rx_valid = 1'b1; rx_data = r[31:0];
            end else begin
                rx_valid = 1'b0;
            end
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        total++; fails++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule